// File: doc/BRIEF.md
# Management-Bus PHY Register Target

This block answers clause 22 management frames on a two-wire serial management bus (clock plus bidirectional data) as if it were a PHY at one fixed address. It samples the management clock and data with the system clock. Once it has seen a long enough run of idle ones, it decodes start, opcode, PHY address and register address. It then either captures sixteen write bits or drives sixteen read bits back onto the data line through an output-enable pair. The pin itself, with its pull-up, sits outside the block.

The register file has 32 entries of 16 bits. Most entries are plain storage. Four of them are synthesised on every read from the advertisement register and a link-up input: the basic status, the link-partner ability, a fixed vendor word and the resolved speed/duplex. Every write also stores into the addressed entry, even where reads of that entry are synthesised. The soft-reset bit of the control register never reads back as 1.

Top module: `mdio_phy_target`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0141, register 3 reads 0x0CC2 and register 4 reads 0x01E1. Every other stored register reads 0, and the target is not driving.
- R2: A frame is accepted only in this form: at least PRE_MIN consecutive ones, a start pair 0 then 1, and an opcode where 10 means read and 01 means write. The opcode is followed by a 5-bit PHY address and then a 5-bit register address, both MSB first. Frames with any other opcode are ignored.
- R3: On a read, the target stays released in the first turnaround bit and drives 0 in the second. It then drives 16 data bits MSB first, each one changing after a rising MDC so that the master samples it on the next rising edge. It releases the line after the last data bit.
- R4: On a write, the master sends two turnaround bits and then 16 data bits, MSB first. Those bits are stored into the addressed register, and a later read of a stored register returns them.
- R5: Register 1 reads 0x782E while linkUp is 1 and 0x0000 while linkUp is 0, whatever was written to it.
- R6: Register 5 reads 0x4001 ORed with bits 8:5 of register 4.
- R7: Register 17 always reads 0x4C00, including after a write to it.
- R8: Register 18 reads 0 while linkUp is 0. Otherwise its bit 10 is register 4 bit 7 OR bit 8, its bit 11 is register 4 bit 8 OR bit 6, and all its other bits are 0.
- R9: After any write, bit 15 of register 0 is 0, so writing 0xB140 to register 0 reads back 0x3140.
- R10: A frame whose PHY address differs from PHY_ADDR changes no register, and the target never drives the line during it.
- R11: A frame preceded by fewer than PRE_MIN consecutive ones is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x faster than MDC |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Link state used by the synthesised registers |
| mdcIn | input | 1 | Management clock from the master |
| mdioIn | input | 1 | Management data as seen on the pin |
| mdioOut | output | 1 | Data the target drives during a read |
| mdioOe | output | 1 | High while the target drives the data pin |

## Verification
The bench builds the target with PHY_ADDR set to 19, PRE_MIN left at 32 and two synchroniser stages. The non-default address means frames sent to the default address 7 have to be rejected, which exercises the address comparison on both values. Leaving the preamble limit at 32 lets a 31-one preamble test the boundary of the preamble counter on one side, while every accepted frame uses exactly 32 ones to test the other side.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_AW   = 5;
  localparam int DATA_W   = 16;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int HDR_BITS = 2 + 2 * REG_AW;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  localparam logic [REG_AW-1:0] REG_CTRL     = 5'd0;
  localparam logic [REG_AW-1:0] REG_STATUS   = 5'd1;
  localparam logic [REG_AW-1:0] REG_ADVERT   = 5'd4;
  localparam logic [REG_AW-1:0] REG_PARTNER  = 5'd5;
  localparam logic [REG_AW-1:0] REG_VENDOR   = 5'd17;
  localparam logic [REG_AW-1:0] REG_RESOLVED = 5'd18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_RTA,
    ST_RDATA,
    ST_WTA,
    ST_WDATA
  } frameStateT;

  typedef struct packed {
    logic loadRd;
    logic shiftRd;
    logic dropBus;
    logic wrEn;
  } mdioStrobeT;
endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter logic [REG_AW-1:0] PHY_ADDR = 5'd7,
  parameter int PRE_MIN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdcIn,
  input  logic              mdioIn,
  output mdioStrobeT        strb,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] wrData,
  output frameStateT        ctlState
);
  localparam int PCW = $clog2(PRE_MIN + 1);
  localparam logic [PCW-1:0] PRE_LIM = PCW'(PRE_MIN);

  logic [SYNC_STAGES-1:0] mdcSync, mdioSync;
  logic mdcPrev, mdcRise, bitIn;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) begin
          mdcSync  <= '0;
          mdioSync <= '1;
        end else begin
          mdcSync  <= mdcIn;
          mdioSync <= mdioIn;
        end
      end
    end else begin : g_sync_multi
      always_ff @(posedge clk) begin
        if (!rstN) begin
          mdcSync  <= '0;
          mdioSync <= '1;
        end else begin
          mdcSync  <= {mdcSync[SYNC_STAGES-2:0], mdcIn};
          mdioSync <= {mdioSync[SYNC_STAGES-2:0], mdioIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) mdcPrev <= 1'b0;
    else       mdcPrev <= mdcSync[SYNC_STAGES-1];
  end

  assign mdcRise = mdcSync[SYNC_STAGES-1] & ~mdcPrev;
  assign bitIn   = mdioSync[SYNC_STAGES-1];

  frameStateT          state;
  logic [PCW-1:0]      preCnt;
  logic [4:0]          bitCnt;
  logic [HDR_BITS-1:0] hdrSh;
  logic [HDR_BITS-1:0] hdrNext;
  logic [DATA_W-1:0]   wdSh;
  logic                phyMatch;

  assign hdrNext  = {hdrSh[HDR_BITS-2:0], bitIn};
  assign phyMatch = (hdrNext[2*REG_AW-1:REG_AW] == PHY_ADDR);
  assign ctlState = state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preCnt  <= '0;
      bitCnt  <= '0;
      hdrSh   <= '0;
      wdSh    <= '0;
      regAddr <= '0;
      wrData  <= '0;
      strb    <= '0;
    end else begin
      strb <= '0;
      if (mdcRise) begin
        if (state != ST_IDLE) preCnt <= '0;
        unique case (state)
          ST_IDLE: begin
            if (bitIn) begin
              if (preCnt < PRE_LIM) preCnt <= preCnt + 1'b1;
            end else begin
              if (preCnt >= PRE_LIM) state <= ST_START;
              preCnt <= '0;
            end
          end
          ST_START: begin
            bitCnt <= '0;
            state  <= bitIn ? ST_HDR : ST_IDLE;
          end
          ST_HDR: begin
            hdrSh  <= hdrNext;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 5'(HDR_BITS - 1)) begin
              bitCnt  <= '0;
              regAddr <= hdrNext[REG_AW-1:0];
              if (phyMatch && hdrNext[HDR_BITS-1 -: 2] == OP_READ)
                state <= ST_RTA;
              else if (phyMatch && hdrNext[HDR_BITS-1 -: 2] == OP_WRITE)
                state <= ST_WTA;
              else
                state <= ST_IDLE;
            end
          end
          ST_RTA: begin
            strb.loadRd <= 1'b1;
            bitCnt      <= '0;
            state       <= ST_RDATA;
          end
          ST_RDATA: begin
            if (bitCnt == 5'(DATA_W)) begin
              strb.dropBus <= 1'b1;
              bitCnt       <= '0;
              state        <= ST_IDLE;
            end else begin
              strb.shiftRd <= 1'b1;
              bitCnt       <= bitCnt + 1'b1;
            end
          end
          ST_WTA: begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 5'd1) begin
              bitCnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            wdSh   <= {wdSh[DATA_W-2:0], bitIn};
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 5'(DATA_W - 1)) begin
              wrData    <= {wdSh[DATA_W-2:0], bitIn};
              strb.wrEn <= 1'b1;
              bitCnt    <= '0;
              state     <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: a header naming another PHY returns the frame engine to idle
  p_foreign_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mdcRise && state == ST_HDR && bitCnt == 5'(HDR_BITS - 1) && !phyMatch)
      |=> state == ST_IDLE);

  // R11: a zero after too short a run of ones does not start a frame
  p_short_pre_r11: assert property (@(posedge clk) disable iff (!rstN)
    (mdcRise && state == ST_IDLE && !bitIn && preCnt < PRE_LIM)
      |=> state == ST_IDLE);

  // R3: at most one datapath action per cycle
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R3: the read data counter never passes the word length
  p_rd_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDATA) |-> (bitCnt <= 5'(DATA_W)));
endmodule

// File: rtl/mdio_reg_datapath.sv
module mdio_reg_datapath
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  mdioStrobeT        strb,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              mdioOut,
  output logic              mdioOe
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [DATA_W-1:0] readVal;
  logic [DATA_W-1:0] shOut;
  logic [DATA_W-1:0] advert;
  logic              adv10Full, adv100Half, adv100Full;

  function automatic logic [DATA_W-1:0] resetValueF(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0141;
      3:       return 16'h0CC2;
      4:       return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= resetValueF(i);
    end else if (strb.wrEn) begin
      regFile[regAddr]        <= wrData;
      regFile[REG_CTRL][15]   <= 1'b0;
    end
  end

  assign advert     = regFile[REG_ADVERT];
  assign adv10Full  = advert[6];
  assign adv100Half = advert[7];
  assign adv100Full = advert[8];

  always_comb begin
    readVal = regFile[regAddr];
    unique case (regAddr)
      REG_STATUS:   readVal = linkUp ? 16'h782E : 16'h0000;
      REG_PARTNER:  readVal = 16'h4001 | (advert & 16'h01E0);
      REG_VENDOR:   readVal = 16'h4C00;
      REG_RESOLVED: begin
        readVal = 16'h0000;
        if (linkUp) begin
          readVal[10] = adv100Half | adv100Full;
          readVal[11] = adv100Full | adv10Full;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shOut   <= '0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else if (strb.loadRd) begin
      shOut   <= readVal;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b1;
    end else if (strb.shiftRd) begin
      mdioOut <= shOut[DATA_W-1];
      shOut   <= {shOut[DATA_W-2:0], 1'b0};
    end else if (strb.dropBus) begin
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end
  end

  // R4: a write strobe to a plain register lands the data there
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && regAddr != REG_CTRL) |=> regFile[$past(regAddr)] == $past(wrData));

  // R9: the soft-reset bit of the control register is never held
  p_ctrl_msb_r9: assert property (@(posedge clk) disable iff (!rstN)
    regFile[REG_CTRL][15] == 1'b0);
endmodule

// File: rtl/mdio_phy_target.sv
module mdio_phy_target
  import mdio_pkg::*;
#(
  parameter logic [REG_AW-1:0] PHY_ADDR = 5'd7,
  parameter int PRE_MIN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkUp,
  input  logic mdcIn,
  input  logic mdioIn,
  output logic mdioOut,
  output logic mdioOe
);
  mdioStrobeT        strb;
  logic [REG_AW-1:0] regAddr;
  logic [DATA_W-1:0] wrData;
  frameStateT        ctlState;

  mdio_frame_ctrl #(
    .PHY_ADDR   (PHY_ADDR),
    .PRE_MIN    (PRE_MIN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .mdcIn   (mdcIn),
    .mdioIn  (mdioIn),
    .strb    (strb),
    .regAddr (regAddr),
    .wrData  (wrData),
    .ctlState(ctlState)
  );

  mdio_reg_datapath u_data (
    .clk    (clk),
    .rstN   (rstN),
    .linkUp (linkUp),
    .strb   (strb),
    .regAddr(regAddr),
    .wrData (wrData),
    .mdioOut(mdioOut),
    .mdioOe (mdioOe)
  );

  // R3, R10: the pin is driven only inside a read data phase of this PHY
  p_drive_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> (ctlState == ST_RDATA || $past(ctlState) == ST_RDATA));
endmodule

// File: tb/sim_mdio_phy_target.sv
module sim_mdio_phy_target;
  localparam logic [4:0] TB_PHY = 5'd19;
  localparam int HALF = 6;
  localparam int PRE  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkUp = 1'b1;
  logic mdc = 1'b0;
  logic mEn = 1'b0;
  logic mVal = 1'b1;
  logic dutOut, dutOe;
  logic mdioLine;
  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign mdioLine = dutOe ? dutOut : (mEn ? mVal : 1'b1);

  mdio_phy_target #(.PHY_ADDR(TB_PHY), .PRE_MIN(32), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .mdcIn(mdc),
    .mdioIn(mdioLine), .mdioOut(dutOut), .mdioOe(dutOe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bitCycle(input logic drv, input logic val, output logic smp, output logic oeS);
    @(posedge clk); #1;
    mdc = 1'b0; mEn = drv; mVal = val;
    repeat (HALF - 1) @(posedge clk);
    #1;
    smp = mdioLine; oeS = dutOe;
    mdc = 1'b1;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic frame(input int preLen, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd, input bit isRead,
                       output logic [15:0] rd, output bit timingOk, output bit anyOe);
    logic s, o;
    logic [11:0] hdr;
    hdr = {op, phy, ra};
    timingOk = 1; anyOe = 0; rd = '0;
    for (int i = 0; i < preLen; i++) begin bitCycle(1, 1, s, o); anyOe |= o; end
    bitCycle(1, 0, s, o); anyOe |= o;
    bitCycle(1, 1, s, o); anyOe |= o;
    for (int i = 11; i >= 0; i--) begin bitCycle(1, hdr[i], s, o); anyOe |= o; end
    if (isRead) begin
      bitCycle(0, 1, s, o); anyOe |= o;
      if (o !== 1'b0) timingOk = 0;
      bitCycle(0, 1, s, o); anyOe |= o;
      if (o !== 1'b1 || s !== 1'b0) timingOk = 0;
      for (int i = 15; i >= 0; i--) begin
        bitCycle(0, 1, s, o); anyOe |= o;
        rd[i] = s;
        if (o !== 1'b1) timingOk = 0;
      end
      bitCycle(0, 1, s, o);
      if (o !== 1'b0) timingOk = 0;
    end else begin
      bitCycle(1, 1, s, o); anyOe |= o;
      bitCycle(1, 0, s, o); anyOe |= o;
      for (int i = 15; i >= 0; i--) begin bitCycle(1, wd[i], s, o); anyOe |= o; end
    end
    @(posedge clk); #1; mEn = 1'b0; mdc = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] ra, input string tag, input logic [15:0] exp);
    logic [15:0] rd; bit ok, any;
    frame(PRE, 2'b10, TB_PHY, ra, 16'h0, 1, rd, ok, any);
    chk({tag, " value"}, rd, exp);
    chk("R3 turnaround/drive window", {15'd0, ok}, 16'd1);
  endtask

  task automatic wrReg(input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] rd; bit ok, any;
    frame(PRE, 2'b01, TB_PHY, ra, wd, 0, rd, ok, any);
    chk("R10 no drive during own write", {15'd0, any}, 16'd0);
  endtask

  task automatic t_reset;
    chk("R1 released after reset", {15'd0, dutOe}, 16'd0);
    rdReg(5'd0, "R1 reg0", 16'h3100);
    rdReg(5'd2, "R1 reg2", 16'h0141);
    rdReg(5'd3, "R1 reg3", 16'h0CC2);
    rdReg(5'd4, "R1 reg4", 16'h01E1);
    rdReg(5'd9, "R1 reg9", 16'h0000);
  endtask

  task automatic t_stored;
    wrReg(5'd9, 16'hA5C3);
    rdReg(5'd9, "R4 reg9", 16'hA5C3);
    wrReg(5'd31, 16'h1234);
    rdReg(5'd31, "R4 reg31", 16'h1234);
    rdReg(5'd9, "R4 reg9 kept", 16'hA5C3);
  endtask

  task automatic t_status;
    rdReg(5'd1, "R5 link up", 16'h782E);
    wrReg(5'd1, 16'hFFFF);
    rdReg(5'd1, "R5 after write", 16'h782E);
    linkUp = 1'b0;
    rdReg(5'd1, "R5 link down", 16'h0000);
    rdReg(5'd18, "R8 link down", 16'h0000);
    linkUp = 1'b1;
  endtask

  task automatic t_partner;
    rdReg(5'd5, "R6 default", 16'h41E1);
    rdReg(5'd18, "R8 default adv", 16'h0C00);
    wrReg(5'd4, 16'h0041);
    rdReg(5'd5, "R6 adv 0041", 16'h4041);
    rdReg(5'd18, "R8 10 full", 16'h0800);
    wrReg(5'd4, 16'h0081);
    rdReg(5'd18, "R8 100 half", 16'h0400);
    wrReg(5'd4, 16'h0101);
    rdReg(5'd5, "R6 adv 0101", 16'h4101);
    rdReg(5'd18, "R8 100 full", 16'h0C00);
    wrReg(5'd4, 16'hFE21);
    rdReg(5'd5, "R6 adv FE21", 16'h4021);
    rdReg(5'd18, "R8 10 half", 16'h0000);
    wrReg(5'd4, 16'h01E1);
  endtask

  task automatic t_vendor;
    rdReg(5'd17, "R7 fixed", 16'h4C00);
    wrReg(5'd17, 16'h0000);
    rdReg(5'd17, "R7 after write", 16'h4C00);
  endtask

  task automatic t_ctrl;
    wrReg(5'd0, 16'hB140);
    rdReg(5'd0, "R9 soft reset bit", 16'h3140);
  endtask

  task automatic t_foreign;
    logic [15:0] rd; bit ok, any;
    frame(PRE, 2'b01, 5'd7, 5'd9, 16'h0000, 0, rd, ok, any);
    chk("R10 foreign write no drive", {15'd0, any}, 16'd0);
    rdReg(5'd9, "R10 reg9 untouched", 16'hA5C3);
    frame(PRE, 2'b10, 5'd7, 5'd9, 16'h0000, 1, rd, ok, any);
    chk("R10 foreign read no drive", {15'd0, any}, 16'd0);
    chk("R10 foreign read line idle", rd, 16'hFFFF);
  endtask

  task automatic t_framing;
    logic [15:0] rd; bit ok, any;
    wrReg(5'd9, 16'hA5C3);
    frame(PRE - 1, 2'b01, TB_PHY, 5'd9, 16'h1111, 0, rd, ok, any);
    rdReg(5'd9, "R11 short preamble ignored", 16'hA5C3);
    frame(PRE, 2'b11, TB_PHY, 5'd9, 16'h2222, 0, rd, ok, any);
    chk("R2 bad opcode no drive", {15'd0, any}, 16'd0);
    rdReg(5'd9, "R2 bad opcode ignored", 16'hA5C3);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (5) @(posedge clk);
    t_reset;
    t_stored;
    t_status;
    t_partner;
    t_vendor;
    t_ctrl;
    t_foreign;
    t_framing;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule